// File: doc/BRIEF.md
# Transaction ID Filter and Byte Accumulator

This unit observes the read-address and write-address channels of a memory port. On each address handshake it compares the transaction ID with a programmed ID, under a don't-care mask. A match produces a one-cycle event strobe: one strobe for reads and a separate strobe for writes. Performance counters use these strobes for their ID-filtered read and write events.

A single 32-bit filter word holds both the ID and the mask. Because only one filter word exists, every counter that uses a filtered event sees the same ID and mask. Each counter slot also carries an 8-bit event code.

When the enhanced mode input is high, each slot coded for a filtered event adds up the bytes moved by the matching bursts. The slot's byte window then reports a byte total instead of a burst count. When the enhanced mode input is low, the byte windows read as zero and nothing is accumulated.

Top module: `txn_id_filter`

## Requirements
- R1: A transaction matches when `((id XOR cfg[ID_W-1:0]) AND NOT cfg[16 +: ID_W]) == 0`. A 1 in the mask field at bits 16 and up marks that ID bit as don't care.
- R2: `rd_hit` is high for exactly one cycle, in the cycle after each rising clock edge at which `ar_valid`, `ar_ready` and an R1 match on `ar_id` are all present. It is low otherwise, including when valid is high without ready.
- R3: `wr_hit` behaves in the same way as `rd_hit`, but on the `aw_*` signals.
- R4: Counter slot n takes its 8-bit event code from `ctr_evt[8n+7:8n]`. Code 0x41 selects matching reads and code 0x42 selects matching writes. A slot holding any other code never accumulates.
- R5: In enhanced mode, each matching burst on a slot's selected channel adds `(len+1) << size` bytes to that slot. The new total is visible on `byte_win[n*ACC_W +: ACC_W]` in the cycle after the handshake.
- R6: The sum saturates at `2**ACC_W-1` and does not wrap.
- R7: When `enh_en` is low, every byte window reads 0 and no accumulation takes place. A total held before the mode was switched off reappears unchanged when `enh_en` returns high.
- R8: `ctr_clr[n]` zeroes slot n at the next edge. A clear takes priority over an add in the same cycle, and it leaves the other slots untouched.
- R9: After reset, both strobes are low and every byte window reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| filt_cfg | input | 32 | Filter word: ID in bits [ID_W-1:0], don't-care mask in bits [16 +: ID_W] |
| enh_en | input | 1 | Enhanced (byte accumulate) mode enable |
| ctr_evt | input | 8*NUM_CTR | Event code for each counter slot |
| ctr_clr | input | NUM_CTR | Clear for each slot's byte total |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | ID_W | Read transaction ID |
| ar_len | input | LEN_W | Read burst length minus one |
| ar_size | input | SIZE_W | Read beat size, log2 of the byte count |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | ID_W | Write transaction ID |
| aw_len | input | LEN_W | Write burst length minus one |
| aw_size | input | SIZE_W | Write beat size, log2 of the byte count |
| rd_hit | output | 1 | Filtered read event strobe |
| wr_hit | output | 1 | Filtered write event strobe |
| byte_win | output | ACC_W*NUM_CTR | Byte total of each slot, zero in basic mode |

## Verification
Each result is due exactly one register stage after the stimulus. The strobes, the byte totals and the clears all appear in the cycle that follows the edge at which the handshake or clear was seen. A change of `enh_en`, however, reaches the byte windows combinationally.

The bench drives every input at the falling edge and updates its arithmetic model with those same inputs. It then waits for one rising edge and compares the strobes and all windows at the next falling edge. As a result, each comparison falls in the cycle in which the expected value is due, never an edge early or late.

// File: rtl/txn_id_filter.sv
module txn_id_filter #(
  parameter int ID_W    = 16,
  parameter int LEN_W   = 8,
  parameter int SIZE_W  = 3,
  parameter int NUM_CTR = 4,
  parameter int ACC_W   = 32,
  parameter logic [7:0] RD_CODE = 8'h41,
  parameter logic [7:0] WR_CODE = 8'h42
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [31:0]              filt_cfg,
  input  logic                     enh_en,
  input  logic [8*NUM_CTR-1:0]     ctr_evt,
  input  logic [NUM_CTR-1:0]       ctr_clr,
  input  logic                     ar_valid,
  input  logic                     ar_ready,
  input  logic [ID_W-1:0]          ar_id,
  input  logic [LEN_W-1:0]         ar_len,
  input  logic [SIZE_W-1:0]        ar_size,
  input  logic                     aw_valid,
  input  logic                     aw_ready,
  input  logic [ID_W-1:0]          aw_id,
  input  logic [LEN_W-1:0]         aw_len,
  input  logic [SIZE_W-1:0]        aw_size,
  output logic                     rd_hit,
  output logic                     wr_hit,
  output logic [ACC_W*NUM_CTR-1:0] byte_win
);
  localparam int BYTES_W = LEN_W + 1 + (2**SIZE_W) - 1;
  localparam int SUM_W   = ((ACC_W > BYTES_W) ? ACC_W : BYTES_W) + 1;
  localparam logic [SUM_W-1:0] SAT = SUM_W'({ACC_W{1'b1}});

  function automatic logic [BYTES_W-1:0] burst_bytes(input logic [LEN_W-1:0] l,
                                                     input logic [SIZE_W-1:0] s);
    logic [BYTES_W-1:0] b;
    b = BYTES_W'(l) + BYTES_W'(1);
    return b << s;
  endfunction

  logic [ID_W-1:0] f_id, f_ign;
  logic ar_fire, aw_fire;
  logic [BYTES_W-1:0] ar_bytes, aw_bytes;
  logic [ACC_W-1:0] acc_q [NUM_CTR];

  assign f_id     = filt_cfg[ID_W-1:0];
  assign f_ign    = filt_cfg[16 +: ID_W];
  assign ar_fire  = ar_valid && ar_ready && (((ar_id ^ f_id) & ~f_ign) == '0);
  assign aw_fire  = aw_valid && aw_ready && (((aw_id ^ f_id) & ~f_ign) == '0);
  assign ar_bytes = burst_bytes(ar_len, ar_size);
  assign aw_bytes = burst_bytes(aw_len, aw_size);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_hit <= 1'b0;
      wr_hit <= 1'b0;
    end else begin
      rd_hit <= ar_fire;
      wr_hit <= aw_fire;
    end
  end

  // R2
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> $past(ar_valid && ar_ready));
  // R3
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |-> $past(aw_valid && aw_ready));

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_slot
    logic [7:0]         evt;
    logic [BYTES_W-1:0] add_val;
    logic [SUM_W-1:0]   sum;

    assign evt     = ctr_evt[8*n +: 8];
    assign add_val = (evt == RD_CODE && ar_fire) ? ar_bytes :
                     (evt == WR_CODE && aw_fire) ? aw_bytes : '0;
    assign sum     = SUM_W'(acc_q[n]) + SUM_W'(add_val);

    always_ff @(posedge clk) begin
      if (!rst_n)
        acc_q[n] <= '0;
      else if (ctr_clr[n])
        acc_q[n] <= '0;
      else if (enh_en && add_val != '0)
        acc_q[n] <= (sum > SAT) ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
    end

    assign byte_win[n*ACC_W +: ACC_W] = enh_en ? acc_q[n] : '0;

    // R8
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_clr[n] |=> acc_q[n] == '0);
    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctr_clr[n] |=> acc_q[n] >= $past(acc_q[n]));
    // R7
    basic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!enh_en && !ctr_clr[n]) |=> $stable(acc_q[n]));
    // R4
    code_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != RD_CODE && evt != WR_CODE && !ctr_clr[n]) |=> $stable(acc_q[n]));
  end
endmodule

// File: tb/txn_id_filter_tb.sv
module txn_id_filter_tb_top;
  localparam int IDW = 4, NC = 4, AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] filt_cfg = '0;
  logic enh_en = 1'b1;
  logic [8*NC-1:0] ctr_evt;
  logic [NC-1:0] ctr_clr = '0;
  logic ar_valid = 0, ar_ready = 0, aw_valid = 0, aw_ready = 0;
  logic [IDW-1:0] ar_id = '0, aw_id = '0;
  logic [7:0] ar_len = '0, aw_len = '0;
  logic [2:0] ar_size = '0, aw_size = '0;
  logic rd_hit, wr_hit;
  logic [AW*NC-1:0] byte_win;

  int checks = 0, fails = 0;
  logic [AW-1:0] exp_acc [NC];
  logic exp_rd = 0, exp_wr = 0;

  always #10 clk = ~clk;

  txn_id_filter #(.ID_W(IDW), .NUM_CTR(NC), .ACC_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .filt_cfg(filt_cfg), .enh_en(enh_en),
    .ctr_evt(ctr_evt), .ctr_clr(ctr_clr),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_len(ar_len), .ar_size(ar_size),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_len(aw_len), .aw_size(aw_size),
    .rd_hit(rd_hit), .wr_hit(wr_hit), .byte_win(byte_win));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic mt(input logic [IDW-1:0] id, input logic [31:0] cfg);
    for (int b = 0; b < IDW; b++)
      if (!cfg[16+b] && id[b] != cfg[b]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [AW-1:0] sat_add(input logic [AW-1:0] a, input int unsigned v);
    longint unsigned s;
    s = longint'(a) + longint'(v);
    return (s > 65535) ? 16'hFFFF : s[AW-1:0];
  endfunction

  task automatic check_all(input string htag, input string wtag);
    chk(htag, rd_hit, exp_rd);
    chk(htag, wr_hit, exp_wr);
    for (int n = 0; n < NC; n++)
      chk(wtag, byte_win[n*AW +: AW], enh_en ? exp_acc[n] : '0);
  endtask

  task automatic cyc(input logic arv, arr, input logic [IDW-1:0] ari, input logic [7:0] arl,
                     input logic [2:0] ars, input logic awv, awr, input logic [IDW-1:0] awi,
                     input logic [7:0] awl, input logic [2:0] aws, input logic [NC-1:0] clr,
                     input string htag, input string wtag);
    logic rf, wf;
    ar_valid = arv; ar_ready = arr; ar_id = ari; ar_len = arl; ar_size = ars;
    aw_valid = awv; aw_ready = awr; aw_id = awi; aw_len = awl; aw_size = aws;
    ctr_clr = clr;
    rf = arv && arr && mt(ari, filt_cfg);
    wf = awv && awr && mt(awi, filt_cfg);
    for (int n = 0; n < NC; n++) begin
      logic [7:0] e;
      e = ctr_evt[8*n +: 8];
      if (clr[n]) exp_acc[n] = '0;
      else if (enh_en && e == 8'h41 && rf) exp_acc[n] = sat_add(exp_acc[n], (int'(arl) + 1) << ars);
      else if (enh_en && e == 8'h42 && wf) exp_acc[n] = sat_add(exp_acc[n], (int'(awl) + 1) << aws);
    end
    exp_rd = rf; exp_wr = wf;
    @(posedge clk); @(negedge clk);
    check_all(htag, wtag);
  endtask

  task automatic idle(input logic [NC-1:0] clr, input string tag);
    cyc(0, 0, '0, '0, '0, 0, 0, '0, '0, '0, clr, tag, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] cfgs [4];
    ctr_evt = {8'h41, 8'h07, 8'h42, 8'h41};
    for (int n = 0; n < NC; n++) exp_acc[n] = '0;
    cfgs[0] = {12'h0, 4'b0000, 12'h0, 4'b0101};
    cfgs[1] = {12'h0, 4'b0011, 12'h0, 4'b1010};
    cfgs[2] = {12'h0, 4'b1111, 12'h0, 4'b0000};
    cfgs[3] = {12'h0, 4'b1000, 12'h0, 4'b0111};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    check_all("R9", "R9");
    rst_n = 1'b1;

    // R1 R2 R3 R5 R4: exhaustive ID sweep under four filters, both channels, stalls included
    for (int c = 0; c < 4; c++) begin
      filt_cfg = cfgs[c];
      idle('1, "R8");
      for (int i = 0; i < 16; i++)
        cyc(1, (i % 3) != 0, IDW'(i), 8'(i), 3'(i % 4),
            1, (i % 4) != 1, IDW'(i ^ 5), 8'(15 - i), 3'((i + 1) % 4), '0, "R1", "R5");
    end

    // R6 saturation
    filt_cfg = 32'h000F_0000;
    idle('1, "R8");
    for (int k = 0; k < 3; k++)
      cyc(1, 1, 4'h3, 8'hFF, 3'd7, 0, 0, '0, '0, '0, '0, "R2", "R6");
    chk("R6", byte_win[0 +: AW], 16'hFFFF);

    // R8 clear of slot 3 during an add; slot 0 unaffected
    cyc(1, 1, 4'h1, 8'h0, 3'd0, 1, 1, 4'h2, 8'h1, 3'd1, 4'b1000, "R8", "R8");
    chk("R8", byte_win[3*AW +: AW], 16'h0);
    cyc(1, 1, 4'h1, 8'h3, 3'd1, 0, 0, '0, '0, '0, '0, "R8", "R8");
    chk("R8", byte_win[3*AW +: AW], 16'd8);

    // R7 basic mode: windows zero, no accumulation, values return afterwards
    enh_en = 1'b0;
    #1 check_all("R7", "R7");
    for (int k = 0; k < 4; k++)
      cyc(1, 1, IDW'(k), 8'h2, 3'd2, 1, 1, IDW'(k), 8'h2, 3'd0, '0, "R7", "R7");
    enh_en = 1'b1;
    #1 check_all("R7", "R7");
    chk("R7", byte_win[3*AW +: AW], 16'd8);

    // R4 other codes: reassign every slot to a non-filter code
    ctr_evt = {8'h00, 8'h40, 8'h43, 8'h05};
    for (int k = 0; k < 4; k++)
      cyc(1, 1, IDW'(k), 8'h1, 3'd0, 1, 1, IDW'(k), 8'h1, 3'd0, '0, "R4", "R4");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule